// File: doc/BRIEF.md
# Timer Compare Output Unit

This block is a 16-bit up/down timer that drives two output pins from compare and wrap events. A small register port configures an 8-bit prescaler, two compare values, the counter itself and, for each pin, an action map. In that map, a compare 0 match, a compare 1 match and a counter wrap can each set, clear or toggle the pin, or leave it alone. When counting starts, each pin is first forced to its own programmed preset level.

The block also keeps event flags with overrun detection. It gives each pin a one-cycle on-chip event strobe, chosen from compare 0 or wrap. It raises a vectored interrupt request: five high vector bits come from a register, and the low bits come from the winning event source. A clock-enable input qualifies every counting cycle. Software writes the registers and then sets the run bit. It services interrupts by reading the flags and clearing them.

Top module: `tmr_cmp_out`

## Requirements
- R1: After reset both pins, both event strobes and the interrupt request are low, and every register, the counter and the flags included, reads 0.
- R2: A write to the control register (address 0) that sets the run bit (bit 0) while the timer is stopped loads each pin with its preset level. The preset level is bit 6 of that pin's output configuration register: address 4 for pin A, address 5 for pin B.
- R3: While running, the counter advances once every 3*(P+1) cycles in which clk_en is high, where P is the prescaler value (address 1, bits 7:0). Cycles with clk_en low do not count.
- R4: Counting direction comes from control bit 1 (0 = up, 1 = down). Up from FFFF gives 0, and down from 0 gives FFFF. Either transition is a wrap event.
- R5: In each output configuration register, bits 1:0 select the action on compare 0, bits 3:2 the action on compare 1 and bits 5:4 the action on wrap. The encoding is 0 keep, 1 set, 2 clear, 3 toggle. A compare event fires when the counter's new value equals the compare register (compare 0 at address 2, compare 1 at address 3).
- R6: When several events reach one pin on the same advance, the wrap action is applied first, then compare 1, then compare 0. The compare 0 action therefore decides the final level.
- R7: Each pin's event strobe is high for exactly the one cycle after its selected event. Bit 7 of the output configuration register selects the event: 0 = compare 0, 1 = wrap.
- R8: The flag register (address 6) sets bit 0 on compare 0, bit 1 on compare 1 and bit 2 on wrap. Bit 3 (compare 0) or bit 4 (compare 1) records an overrun when that compare event occurs while its flag is still set.
- R9: Writing 0 to a flag bit clears it. Writing 1 to a flag bit leaves it unchanged.
- R10: The interrupt request is high when the global enable is set and at least one flag has its enable set. In the interrupt configuration register (address 7), bit 0 enables compare 0, bit 1 enables compare 1, bit 2 enables wrap, bit 3 enables capture (stored only), bit 7 is the global enable and bits 12:8 hold the vector high bits. The vector is {high bits, code}, where the code is 000 for wrap, 100 for compare 1 and 010 for compare 0, in that order of priority.
- R11: While the run bit is clear, the counter holds its value. The counter can be read and written at address 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Qualifies counting cycles |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| pin_a | output | 1 | Output pin A |
| pin_b | output | 1 | Output pin B |
| evt_a | output | 1 | On-chip event strobe for pin A |
| evt_b | output | 1 | On-chip event strobe for pin B |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 8 | Interrupt vector |

## Verification
The assertions check on every cycle that the counter moves only on a prescaler tick or a software load, and that it holds while stopped. They also check that an up-count from all ones wraps to zero, that the preset lands on a start, that each event strobe lasts a single cycle, and that any active request carries a legal low vector code and a set flag. Only the bench scenarios can show the actual pin levels produced by each action code. The same holds for the ordering when a wrap and a compare land on the same advance, the exact tick period for a given prescaler value, overrun recording, and the write-0-to-clear flag behaviour. They are also the only check on which vector wins when several sources are pending.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRESC = 4'd1;
    localparam logic [ADDR_W-1:0] A_CMP0  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CMP1  = 4'd3;
    localparam logic [ADDR_W-1:0] A_OUTA  = 4'd4;
    localparam logic [ADDR_W-1:0] A_OUTB  = 4'd5;
    localparam logic [ADDR_W-1:0] A_FLAGS = 4'd6;
    localparam logic [ADDR_W-1:0] A_INTC  = 4'd7;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd8;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_FLIP = 2'd3
    } pin_act_e;

    // [7] event select, [6] preset, [5:4] wrap, [3:2] cmp1, [1:0] cmp0
    typedef struct packed {
        logic     ev_sel;
        logic     preset;
        pin_act_e on_wrap;
        pin_act_e on_cmp1;
        pin_act_e on_cmp0;
    } out_cfg_t;

    // [4] ovr1, [3] ovr0, [2] wrap, [1] cmp1, [0] cmp0
    typedef struct packed {
        logic ovr1;
        logic ovr0;
        logic wrap;
        logic cmp1;
        logic cmp0;
    } flags_t;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int PRE_W  = 8,
    parameter int PHASES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             clk_en,
    input  logic [PRE_W-1:0] reload,
    output logic             tick
);
    localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [PRE_W-1:0] pcnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (restart) begin
            st_d.ph   = '0;
            st_d.pcnt = reload;
        end else if (run && clk_en) begin
            if (st_q.ph == PH_LAST) begin
                st_d.ph = '0;
                if (st_q.pcnt == '0) begin
                    tick      = 1'b1;
                    st_d.pcnt = reload;
                end else begin
                    st_d.pcnt = st_q.pcnt - 1'b1;
                end
            end else begin
                st_d.ph = st_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_pin_unit.sv
module tmr_pin_unit
    import tmr_cmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  out_cfg_t cfg,
    input  logic     hit0,
    input  logic     hit1,
    input  logic     hit_wrap,
    output logic     pin,
    output logic     evt
);
    typedef struct packed {
        logic pin;
        logic evt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic apply_act(pin_act_e act, logic lvl);
        case (act)
            ACT_SET:  return 1'b1;
            ACT_CLR:  return 1'b0;
            ACT_FLIP: return ~lvl;
            default:  return lvl;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.pin = cfg.preset;
        end else begin
            if (hit_wrap) st_d.pin = apply_act(cfg.on_wrap, st_d.pin);
            if (hit1)     st_d.pin = apply_act(cfg.on_cmp1, st_d.pin);
            if (hit0)     st_d.pin = apply_act(cfg.on_cmp0, st_d.pin);
        end
        st_d.evt = cfg.ev_sel ? hit_wrap : hit0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin = st_q.pin;
    assign evt = st_q.evt;
endmodule

// File: rtl/tmr_irq_sel.sv
module tmr_irq_sel
    import tmr_cmp_pkg::*;
#(
    parameter int VHI_W = 5
) (
    input  flags_t           flags,
    input  logic [2:0]       ien,
    input  logic             gie,
    input  logic [VHI_W-1:0] vhi,
    output logic             irq,
    output logic [VHI_W+2:0] vec
);
    logic [2:0] pend;
    logic [2:0] code;

    always_comb begin
        pend = {flags.wrap, flags.cmp1, flags.cmp0} & ien;
        if (pend[2])      code = 3'b000;
        else if (pend[1]) code = 3'b100;
        else if (pend[0]) code = 3'b010;
        else              code = 3'b000;
        irq = gie && (pend != 3'b000);
        vec = {vhi, code};
    end
endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out
    import tmr_cmp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int VHI_W  = 5,
    parameter int PHASES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              pin_a,
    output logic              pin_b,
    output logic              evt_a,
    output logic              evt_b,
    output logic              irq,
    output logic [VHI_W+2:0]  irq_vec
);
    localparam int NOUT = 2;

    typedef struct packed {
        logic             run;
        logic             down;
        logic [PRE_W-1:0] presc;
        logic [CNT_W-1:0] cmp0;
        logic [CNT_W-1:0] cmp1;
        logic [CNT_W-1:0] cnt;
        out_cfg_t         oa;
        out_cfg_t         ob;
        flags_t           flags;
        logic [2:0]       ien;
        logic             cap_en;
        logic             gie;
        logic [VHI_W-1:0] vhi;
    } regs_t;

    regs_t r_d, r_q;

    logic             tick, start, cnt_wr, wrap, hit0, hit1;
    logic [CNT_W-1:0] cnt_nx;
    logic             run_q, dir_q, preset_a, preset_b;
    logic [CNT_W-1:0] cnt_q;
    logic [4:0]       flags_q;

    assign start  = wr_en && (wr_addr == A_CTRL) && wr_data[0] && !r_q.run;
    assign cnt_wr = wr_en && (wr_addr == A_COUNT);

    tmr_tick_gen #(.PRE_W(PRE_W), .PHASES(PHASES)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.run),
        .restart (start),
        .clk_en  (clk_en),
        .reload  (r_q.presc),
        .tick    (tick)
    );

    always_comb begin
        r_d    = r_q;
        cnt_nx = r_q.down ? r_q.cnt - 1'b1 : r_q.cnt + 1'b1;
        wrap   = tick && (r_q.down ? (r_q.cnt == '0) : (&r_q.cnt));
        hit0   = tick && (cnt_nx == r_q.cmp0);
        hit1   = tick && (cnt_nx == r_q.cmp1);

        if (tick) r_d.cnt = cnt_nx;

        if (wr_en) begin
            case (wr_addr)
                A_CTRL:  {r_d.down, r_d.run} = wr_data[1:0];
                A_PRESC: r_d.presc = wr_data[PRE_W-1:0];
                A_CMP0:  r_d.cmp0  = wr_data;
                A_CMP1:  r_d.cmp1  = wr_data;
                A_OUTA:  r_d.oa    = out_cfg_t'(wr_data[7:0]);
                A_OUTB:  r_d.ob    = out_cfg_t'(wr_data[7:0]);
                A_FLAGS: r_d.flags = r_q.flags & flags_t'(wr_data[4:0]);
                A_INTC: begin
                    r_d.ien    = wr_data[2:0];
                    r_d.cap_en = wr_data[3];
                    r_d.gie    = wr_data[7];
                    r_d.vhi    = wr_data[8 +: VHI_W];
                end
                A_COUNT: r_d.cnt = wr_data;
                default: ;
            endcase
        end

        if (hit0) begin
            r_d.flags.cmp0 = 1'b1;
            if (r_q.flags.cmp0) r_d.flags.ovr0 = 1'b1;
        end
        if (hit1) begin
            r_d.flags.cmp1 = 1'b1;
            if (r_q.flags.cmp1) r_d.flags.ovr1 = 1'b1;
        end
        if (wrap) r_d.flags.wrap = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    out_cfg_t          ocfg [NOUT];
    logic [NOUT-1:0]   pin_w, evt_w;

    assign ocfg[0] = r_q.oa;
    assign ocfg[1] = r_q.ob;

    for (genvar g = 0; g < NOUT; g++) begin : g_pin
        tmr_pin_unit u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (start),
            .cfg      (ocfg[g]),
            .hit0     (hit0),
            .hit1     (hit1),
            .hit_wrap (wrap),
            .pin      (pin_w[g]),
            .evt      (evt_w[g])
        );
    end

    assign pin_a = pin_w[0];
    assign pin_b = pin_w[1];
    assign evt_a = evt_w[0];
    assign evt_b = evt_w[1];

    tmr_irq_sel #(.VHI_W(VHI_W)) u_irq (
        .flags (r_q.flags),
        .ien   (r_q.ien),
        .gie   (r_q.gie),
        .vhi   (r_q.vhi),
        .irq   (irq),
        .vec   (irq_vec)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data[1:0] = {r_q.down, r_q.run};
            A_PRESC: rd_data[PRE_W-1:0] = r_q.presc;
            A_CMP0:  rd_data = r_q.cmp0;
            A_CMP1:  rd_data = r_q.cmp1;
            A_OUTA:  rd_data[7:0] = r_q.oa;
            A_OUTB:  rd_data[7:0] = r_q.ob;
            A_FLAGS: rd_data[4:0] = r_q.flags;
            A_INTC: begin
                rd_data[2:0]         = r_q.ien;
                rd_data[3]           = r_q.cap_en;
                rd_data[7]           = r_q.gie;
                rd_data[8 +: VHI_W]  = r_q.vhi;
            end
            A_COUNT: rd_data = r_q.cnt;
            default: ;
        endcase
    end

    assign run_q    = r_q.run;
    assign dir_q    = r_q.down;
    assign cnt_q    = r_q.cnt;
    assign flags_q  = r_q.flags;
    assign preset_a = r_q.oa.preset;
    assign preset_b = r_q.ob.preset;
endmodule

// File: rtl/tmr_cmp_out_chk.sv
module tmr_cmp_out_chk #(
    parameter int CNT_W = 16,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cnt_wr,
    input logic             tick,
    input logic             run_q,
    input logic             dir_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [4:0]       flags_q,
    input logic             preset_a,
    input logic             preset_b,
    input logic             pin_a,
    input logic             pin_b,
    input logic             evt_a,
    input logic             evt_b,
    input logic             irq,
    input logic [VEC_W-1:0] irq_vec
);
    assert_preset_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (pin_a == $past(preset_a)) && (pin_b == $past(preset_b)));

    assert_count_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> ($past(tick) || $past(cnt_wr)));

    assert_up_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick && !dir_q && (&cnt_q) && !cnt_wr) |-> (cnt_q == '0));

    assert_evt_a_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_a |=> !evt_a);

    assert_evt_b_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_b |=> !evt_b);

    assert_vec_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vec[2:0] == 3'b000 || irq_vec[2:0] == 3'b010 || irq_vec[2:0] == 3'b100));

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags_q != 5'd0));

    assert_hold_when_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run_q) && !$past(cnt_wr)) |-> $stable(cnt_q));
endmodule

bind tmr_cmp_out tmr_cmp_out_chk #(.CNT_W(CNT_W), .VEC_W(VHI_W + 3)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cnt_wr   (cnt_wr),
    .tick     (tick),
    .run_q    (run_q),
    .dir_q    (dir_q),
    .cnt_q    (cnt_q),
    .flags_q  (flags_q),
    .preset_a (preset_a),
    .preset_b (preset_b),
    .pin_a    (pin_a),
    .pin_b    (pin_b),
    .evt_a    (evt_a),
    .evt_b    (evt_b),
    .irq      (irq),
    .irq_vec  (irq_vec)
);

// File: tb/test_tmr_cmp_out.sv
module test_tmr_cmp_out;
    localparam int CLK_PERIOD = 10;

    localparam int S_PIN_A = 0, S_PIN_B = 1, S_EVT_A = 2, S_EVT_B = 3;
    localparam int S_IRQ = 4, S_VEC = 5, S_REG = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pin_a, pin_b, evt_a, evt_b, irq;
    logic [7:0]  irq_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        int          sel;
        logic [15:0] exp;
    } item_t;

    item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cmp_out i_tmr_cmp_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pin_a   (pin_a),
        .pin_b   (pin_b),
        .evt_a   (evt_a),
        .evt_b   (evt_b),
        .irq     (irq),
        .irq_vec (irq_vec)
    );

    function automatic logic [15:0] observe(int sel);
        case (sel)
            S_PIN_A: return {15'd0, pin_a};
            S_PIN_B: return {15'd0, pin_b};
            S_EVT_A: return {15'd0, evt_a};
            S_EVT_B: return {15'd0, evt_b};
            S_IRQ:   return {15'd0, irq};
            S_VEC:   return {8'd0, irq_vec};
            default: return rd_data;
        endcase
    endfunction

    // monitor: compares pending expectations away from the active edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [15:0] obs;
            it  = sbq.pop_front();
            obs = observe(it.sel);
            n_chk++;
            if (obs !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, obs, it.exp);
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        step(1);
        wr_en   = 1'b0;
    endtask

    task automatic expect_sig(string tag, int sel, logic [15:0] exp);
        item_t it;
        it.tag = tag;
        it.sel = sel;
        it.exp = exp;
        sbq.push_back(it);
    endtask

    task automatic expect_reg(string tag, logic [3:0] a, logic [15:0] exp);
        rd_addr = a;
        expect_sig(tag, S_REG, exp);
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        expect_sig("R1 pin_a", S_PIN_A, 16'd0);
        expect_sig("R1 pin_b", S_PIN_B, 16'd0);
        expect_sig("R1 evt_a", S_EVT_A, 16'd0);
        expect_sig("R1 irq",   S_IRQ,   16'd0);
        expect_reg("R1 count", 4'd8, 16'h0000);
        expect_reg("R1 flags", 4'd6, 16'h0000);

        // configuration: A = {cmp0 set, cmp1 toggle, wrap clear, preset 0, evt on cmp0}
        //                B = {cmp0 clear, cmp1 set, wrap keep, preset 1, evt on wrap}
        wr(4'd1, 16'h0000);
        wr(4'd2, 16'd2);
        wr(4'd3, 16'd4);
        wr(4'd4, 16'h002D);
        wr(4'd5, 16'h00C6);
        wr(4'd0, 16'h0001);
        expect_sig("R2 preset a", S_PIN_A, 16'd0);
        expect_sig("R2 preset b", S_PIN_B, 16'd1);
        step(2);
        expect_reg("R3 count before first tick", 4'd8, 16'd0);
        step(1);
        expect_reg("R3 count after 3 cycles", 4'd8, 16'd1);
        step(3);
        expect_sig("R5 cmp0 set a",   S_PIN_A, 16'd1);
        expect_sig("R5 cmp0 clear b", S_PIN_B, 16'd0);
        expect_sig("R7 evt_a on cmp0", S_EVT_A, 16'd1);
        expect_sig("R7 evt_b idle",    S_EVT_B, 16'd0);
        step(1);
        expect_sig("R7 evt_a one cycle", S_EVT_A, 16'd0);
        step(5);
        expect_sig("R5 cmp1 toggle a", S_PIN_A, 16'd0);
        expect_sig("R5 cmp1 set b",    S_PIN_B, 16'd1);
        expect_reg("R8 flags cmp0 cmp1", 4'd6, 16'h0003);

        // R11: stop holds the counter
        wr(4'd0, 16'h0000);
        step(10);
        expect_reg("R11 hold while stopped", 4'd8, 16'd4);

        // R9: write-0 clears, write-1 keeps
        wr(4'd6, 16'h0002);
        expect_reg("R9 flags after partial clear", 4'd6, 16'h0002);

        // R4/R6: wrap and cmp0 on the same advance
        wr(4'd8, 16'hFFFE);
        wr(4'd2, 16'h0000);
        wr(4'd0, 16'h0001);
        step(6);
        expect_sig("R6 a: wrap clear then cmp0 set", S_PIN_A, 16'd1);
        expect_sig("R6 b: cmp0 clear",               S_PIN_B, 16'd0);
        expect_sig("R7 evt_b on wrap",               S_EVT_B, 16'd1);
        expect_sig("R7 evt_a on cmp0 at wrap",       S_EVT_A, 16'd1);
        expect_reg("R4 up wrap to zero", 4'd8, 16'h0000);
        step(1);
        expect_reg("R8 flags cmp0 cmp1 wrap", 4'd6, 16'h0007);
        step(11);
        expect_sig("R5 toggle a again", S_PIN_A, 16'd0);
        expect_sig("R5 set b",          S_PIN_B, 16'd1);
        expect_reg("R8 cmp1 overrun", 4'd6, 16'h0017);

        // R4: down count, cmp0 overrun then underflow
        wr(4'd0, 16'h0000);
        wr(4'd8, 16'h0001);
        wr(4'd0, 16'h0003);
        step(3);
        expect_sig("R5 down cmp0 set a", S_PIN_A, 16'd1);
        expect_sig("R7 evt_a down cmp0", S_EVT_A, 16'd1);
        expect_reg("R4 down to zero", 4'd8, 16'h0000);
        step(3);
        expect_sig("R4 underflow clears a", S_PIN_A, 16'd0);
        expect_sig("R4 underflow evt_b",    S_EVT_B, 16'd1);
        expect_reg("R4 underflow to FFFF", 4'd8, 16'hFFFF);
        step(1);
        expect_reg("R8 cmp0 overrun", 4'd6, 16'h001F);
        wr(4'd0, 16'h0000);

        // R10: interrupt and vector
        wr(4'd7, 16'h1584);
        expect_sig("R10 irq wrap", S_IRQ, 16'd1);
        expect_sig("R10 vec wrap", S_VEC, 16'h00A8);
        wr(4'd7, 16'h1582);
        expect_sig("R10 vec cmp1", S_VEC, 16'h00AC);
        wr(4'd7, 16'h1581);
        expect_sig("R10 vec cmp0", S_VEC, 16'h00AA);
        wr(4'd7, 16'h1507);
        expect_sig("R10 global off", S_IRQ, 16'd0);
        wr(4'd7, 16'h1587);
        expect_sig("R10 priority wrap first", S_VEC, 16'h00A8);
        wr(4'd6, 16'h001B);
        expect_sig("R10 priority cmp1 next", S_VEC, 16'h00AC);
        expect_reg("R9 clear wrap only", 4'd6, 16'h001B);
        wr(4'd6, 16'h0000);
        expect_sig("R10 no flags no irq", S_IRQ, 16'd0);

        // R3: prescaler 2 and clk_en pause
        wr(4'd1, 16'h0002);
        wr(4'd8, 16'h0000);
        wr(4'd2, 16'h0100);
        wr(4'd0, 16'h0001);
        step(8);
        expect_reg("R3 prescale 2 before tick", 4'd8, 16'd0);
        step(1);
        expect_reg("R3 prescale 2 tick at 9", 4'd8, 16'd1);
        clk_en = 1'b0;
        step(20);
        expect_reg("R3 clk_en low pauses", 4'd8, 16'd1);
        clk_en = 1'b1;
        step(9);
        expect_reg("R3 resumes after 9 enabled", 4'd8, 16'd2);

        step(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule